// File: doc/BRIEF.md
# Virtual Address Region and Access Gate

This block sits in front of a translation lookaside buffer. It handles data reads, data writes and instruction fetches. For each access it sorts the 32-bit virtual address into one of three outcomes:

- the address passes through with no translation;
- the access is refused with an address error;
- the access needs a table lookup.

The TLB itself lives outside the block. In the lookup case, the block takes the external lookup result in the same cycle: hit, multiple hit, and the writable, user and dirty flags of the matching entry. It then checks privilege, writability and the dirty state, and reports at most one exception on a one-hot vector.

Faults that come from the table (miss, protection, initial page write, multiple hit) also load two registers on the clock edge that ends the access. The fault-address register takes the full virtual address. The page-table-entry-high register keeps its low ten bits (the address-space identifier and its neighbours), and its upper bits take the page part of the faulting address. Software can load the page-table-entry-high register directly. The block also reports whether the external lookup must compare address-space identifiers.

Top module: `va_access_gate`

## Requirements
- R1: A privileged read or write (kind 2'b00 read, 2'b01 write, 2'b11 treated as read) to 0x80000000..0xBFFFFFFF or to 0xE0000000 and above drives pass_thru=1 with no exception, whatever ctl_xlate_en holds. Such an access to 0xC0000000..0xDFFFFFFF needs a lookup when ctl_xlate_en=1.
- R2: A user read or write to 0xE0000000..0xE3FFFFFF passes through when ctl_sq_lock=0. Any other user read or write with bit 31 set raises an address error: exc_vec bit 0 for a read, bit 1 for a write.
- R3: An instruction fetch (kind 2'b10) is handled as follows. A privileged fetch to 0x80000000..0xBFFFFFFF passes through. A privileged fetch at 0xE0000000 or above raises exc_vec bit 0. A user fetch with bit 31 set raises exc_vec bit 0.
- R4: With ctl_xlate_en=0, every access that is not refused by R2 or R3 passes through, and need_lookup stays 0.
- R5: asid_check is 1 when need_lookup=1 and either ctl_sv_shared=0 or acc_priv=0. Otherwise it is 0.
- R6: During a lookup, lk_multi=1 raises only exc_vec bit 7. This wins over a miss and over the protection and dirty checks. Otherwise, lk_hit=0 raises bit 2 for a read or fetch and bit 3 for a write.
- R7: On a hit, a privileged write needs lk_writable. A user write needs both lk_writable and lk_user. A user read or fetch needs lk_user. A privileged read or fetch always passes this check. A failure raises bit 4 for a read or fetch and bit 5 for a write.
- R8: A write that passes R7 on an entry with lk_dirty=0 raises exc_vec bit 6 (initial page write). Protection faults win over this.
- R9: At most one exc_vec bit is set. pass_thru and need_lookup are never both set. A passed-through access raises no exception.
- R10: On the clock edge of an access that raises bit 2, 3, 4, 5, 6 or 7, fault_addr_q takes acc_va. pte_hi_q[31:10] takes acc_va[31:10] and pte_hi_q[9:0] is kept. Address errors and clean accesses leave both registers unchanged.
- R11: hi_wr loads hi_wdata into pte_hi_q on the clock edge. A capture from R10 in the same cycle wins over the software load.
- R12: After reset, fault_addr_q and pte_hi_q are 0. With acc_valid=0, pass_thru, need_lookup, asid_check and exc_vec are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_priv | input | 1 | Access made in privileged mode |
| acc_va | input | 32 | Virtual address |
| ctl_xlate_en | input | 1 | Address translation enabled |
| ctl_sv_shared | input | 1 | Privileged accesses skip identifier matching |
| ctl_sq_lock | input | 1 | Close the user window at 0xE0000000..0xE3FFFFFF |
| lk_hit | input | 1 | External lookup found an entry |
| lk_multi | input | 1 | External lookup found several entries |
| lk_writable | input | 1 | Entry allows writes |
| lk_user | input | 1 | Entry allows user access |
| lk_dirty | input | 1 | Entry has been written before |
| hi_wr | input | 1 | Software load of the page-table-entry-high register |
| hi_wdata | input | 32 | Value for that load |
| pass_thru | output | 1 | Access passes untranslated |
| need_lookup | output | 1 | Access goes through the table |
| asid_check | output | 1 | Lookup must match the address-space identifier |
| exc_vec | output | 8 | One-hot exception code |
| fault_addr_q | output | 32 | Captured faulting virtual address |
| pte_hi_q | output | 32 | Page-table-entry-high register |

## Verification
The region rules are tried by walking addresses on both sides of each region edge: 0x7FFFFFFF/0x80000000, 0xBFFFFFFF/0xC0000000, 0xDFFFFFFF/0xE0000000 and 0xE3FFFFFF/0xE4000000. Each edge is crossed under both privilege levels and all three access kinds, so a wrong boundary or a kind mixed into the wrong rule changes the outcome. The lookup checks combine conflicting inputs, such as a multiple hit together with a miss and failing flags, or a protection failure on a clean page. These cases separate the priority order from the single checks. The capture registers are loaded with a known low field first. They are then followed through table faults, address errors and a same-cycle software load, which shows which events may write them and which part of the old value survives.

// File: rtl/va_gate_pkg.sv
package va_gate_pkg;

  localparam int VA_W  = 32;
  localparam int EXC_W = 8;

  // access kinds
  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  // exception bit positions
  localparam int EX_RD_ADDR  = 0;
  localparam int EX_WR_ADDR  = 1;
  localparam int EX_RD_MISS  = 2;
  localparam int EX_WR_MISS  = 3;
  localparam int EX_RD_PROT  = 4;
  localparam int EX_WR_PROT  = 5;
  localparam int EX_INIT_WR  = 6;
  localparam int EX_MULTI    = 7;

  typedef enum logic [1:0] {
    ZN_LOW    = 2'd0,  // bit 31 clear, always mapped
    ZN_DIRECT = 2'd1,  // 0x80000000..0xBFFFFFFF
    ZN_MAPHI  = 2'd2,  // 0xC0000000..0xDFFFFFFF
    ZN_CTRL   = 2'd3   // 0xE0000000 and up
  } zone_e;

  function automatic zone_e f_zone(input logic [2:0] top3);
    case (top3)
      3'b100, 3'b101: return ZN_DIRECT;
      3'b110:         return ZN_MAPHI;
      3'b111:         return ZN_CTRL;
      default:        return ZN_LOW;
    endcase
  endfunction

  // user window 0xE0000000..0xE3FFFFFF is selected by the six top bits
  function automatic logic f_in_user_window(input logic [5:0] top6);
    return top6 == 6'b111000;
  endfunction

  // protection rule: returns 1 when the entry flags allow the access
  function automatic logic f_perm_ok(input logic is_wr, input logic priv,
                                     input logic wr_ok, input logic usr_ok);
    if (is_wr) return priv ? wr_ok : (wr_ok & usr_ok);
    return priv | usr_ok;
  endfunction

endpackage

// File: rtl/va_zone_decode.sv
module va_zone_decode
  import va_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       priv,
  input  logic [5:0] va_top,
  input  logic       xlate_en,
  input  logic       sq_lock,
  output logic       z_pass,
  output logic       z_aerr,
  output logic       z_map
);

  zone_e zone;
  logic  is_fetch;
  logic  pre_pass, pre_aerr, pre_map;

  assign zone     = f_zone(va_top[5:3]);
  assign is_fetch = (kind == KIND_FETCH);

  always_comb begin
    pre_pass = 1'b0;
    pre_aerr = 1'b0;
    pre_map  = 1'b0;
    if (zone == ZN_LOW) begin
      pre_map = 1'b1;
    end else if (priv) begin
      case (zone)
        ZN_DIRECT: pre_pass = 1'b1;
        ZN_MAPHI:  pre_map  = 1'b1;
        default:   begin
          if (is_fetch) pre_aerr = 1'b1;
          else          pre_pass = 1'b1;
        end
      endcase
    end else begin
      if (!is_fetch && f_in_user_window(va_top) && !sq_lock) pre_pass = 1'b1;
      else                                                   pre_aerr = 1'b1;
    end
  end

  // translation disabled: mapped accesses fall back to pass-through
  assign z_map  = valid & pre_map & xlate_en;
  assign z_pass = valid & (pre_pass | (pre_map & ~xlate_en));
  assign z_aerr = valid & pre_aerr;

  AST_ZONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones({z_pass, z_aerr, z_map}) == 1); // R9
  AST_USER_HI_NOT_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !priv && va_top[5] |-> !z_map); // R2
  AST_FETCH_CTRL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_fetch && va_top[5:3] == 3'b111 |-> z_aerr); // R3
  AST_NO_MAP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> !z_map); // R4

endmodule

// File: rtl/va_perm_judge.sv
module va_perm_judge
  import va_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic is_wr,
  input  logic priv,
  input  logic hit,
  input  logic multi,
  input  logic wr_ok,
  input  logic usr_ok,
  input  logic dirty,
  output logic t_multi,
  output logic t_miss,
  output logic t_prot,
  output logic t_init
);

  logic single_hit;
  logic flags_ok;

  assign single_hit = en & ~multi & hit;
  assign flags_ok   = f_perm_ok(is_wr, priv, wr_ok, usr_ok);

  assign t_multi = en & multi;
  assign t_miss  = en & ~multi & ~hit;
  assign t_prot  = single_hit & ~flags_ok;
  assign t_init  = single_hit & flags_ok & is_wr & ~dirty;

  AST_INIT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    t_init |-> is_wr && hit && !dirty); // R8
  AST_PRIV_READ_NEVER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    en && priv && !is_wr |-> !t_prot); // R7

endmodule

// File: rtl/va_fault_capture.sv
module va_fault_capture #(
  parameter int AW       = 32,
  parameter int PAGE_LSB = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] va,
  input  logic          hi_wr,
  input  logic [AW-1:0] hi_wdata,
  output logic [AW-1:0] fault_addr_q,
  output logic [AW-1:0] pte_hi_q
);

  localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr_q <= '0;
      pte_hi_q     <= '0;
    end else if (cap_en) begin
      fault_addr_q <= va;
      pte_hi_q     <= (pte_hi_q & ~PAGE_MASK) | (va & PAGE_MASK);
    end else if (hi_wr) begin
      pte_hi_q     <= hi_wdata;
    end
  end

  AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> fault_addr_q == $past(va)); // R10
  AST_CAPTURE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> pte_hi_q[AW-1:PAGE_LSB] == $past(va[AW-1:PAGE_LSB])
               && pte_hi_q[PAGE_LSB-1:0] == $past(pte_hi_q[PAGE_LSB-1:0])); // R10
  AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !hi_wr |=> $stable(fault_addr_q) && $stable(pte_hi_q)); // R10
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && hi_wr |=> pte_hi_q == $past(hi_wdata)); // R11

endmodule

// File: rtl/va_access_gate.sv
module va_access_gate
  import va_gate_pkg::*;
#(
  parameter int AW       = VA_W,
  parameter int PAGE_LSB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic             acc_priv,
  input  logic [AW-1:0]    acc_va,
  input  logic             ctl_xlate_en,
  input  logic             ctl_sv_shared,
  input  logic             ctl_sq_lock,
  input  logic             lk_hit,
  input  logic             lk_multi,
  input  logic             lk_writable,
  input  logic             lk_user,
  input  logic             lk_dirty,
  input  logic             hi_wr,
  input  logic [AW-1:0]    hi_wdata,
  output logic             pass_thru,
  output logic             need_lookup,
  output logic             asid_check,
  output logic [EXC_W-1:0] exc_vec,
  output logic [AW-1:0]    fault_addr_q,
  output logic [AW-1:0]    pte_hi_q
);

  logic is_wr;
  logic z_pass, z_aerr, z_map;
  logic t_multi, t_miss, t_prot, t_init;
  logic tlb_fault;

  assign is_wr = (acc_kind == KIND_WRITE);

  va_zone_decode u_zone (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (acc_valid),
    .kind     (acc_kind),
    .priv     (acc_priv),
    .va_top   (acc_va[AW-1 -: 6]),
    .xlate_en (ctl_xlate_en),
    .sq_lock  (ctl_sq_lock),
    .z_pass   (z_pass),
    .z_aerr   (z_aerr),
    .z_map    (z_map)
  );

  va_perm_judge u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (z_map),
    .is_wr   (is_wr),
    .priv    (acc_priv),
    .hit     (lk_hit),
    .multi   (lk_multi),
    .wr_ok   (lk_writable),
    .usr_ok  (lk_user),
    .dirty   (lk_dirty),
    .t_multi (t_multi),
    .t_miss  (t_miss),
    .t_prot  (t_prot),
    .t_init  (t_init)
  );

  always_comb begin
    exc_vec             = '0;
    exc_vec[EX_RD_ADDR] = z_aerr & ~is_wr;
    exc_vec[EX_WR_ADDR] = z_aerr &  is_wr;
    exc_vec[EX_RD_MISS] = t_miss & ~is_wr;
    exc_vec[EX_WR_MISS] = t_miss &  is_wr;
    exc_vec[EX_RD_PROT] = t_prot & ~is_wr;
    exc_vec[EX_WR_PROT] = t_prot &  is_wr;
    exc_vec[EX_INIT_WR] = t_init;
    exc_vec[EX_MULTI]   = t_multi;
  end

  assign pass_thru   = z_pass;
  assign need_lookup = z_map;
  assign asid_check  = z_map & (~ctl_sv_shared | ~acc_priv);
  assign tlb_fault   = t_multi | t_miss | t_prot | t_init;

  va_fault_capture #(.AW(AW), .PAGE_LSB(PAGE_LSB)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (tlb_fault),
    .va           (acc_va),
    .hi_wr        (hi_wr),
    .hi_wdata     (hi_wdata),
    .fault_addr_q (fault_addr_q),
    .pte_hi_q     (pte_hi_q)
  );

  AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exc_vec)); // R9
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |-> exc_vec == '0 && !need_lookup); // R9
  AST_MULTI_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    need_lookup && lk_multi |-> exc_vec == EXC_W'(1) << EX_MULTI); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !pass_thru && !need_lookup && !asid_check && exc_vec == '0); // R12
  AST_USER_ASID: assert property (@(posedge clk) disable iff (!rst_n)
    need_lookup && !acc_priv |-> asid_check); // R5
  AST_PRIV_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_priv && acc_va[AW-1 -: 2] == 2'b10 |-> pass_thru); // R1

endmodule

// File: tb/sim_va_access_gate.sv
module sim_va_access_gate;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic        acc_priv = 1'b0;
  logic [31:0] acc_va = '0;
  logic        ctl_xlate_en = 1'b0;
  logic        ctl_sv_shared = 1'b0;
  logic        ctl_sq_lock = 1'b0;
  logic        lk_hit = 1'b0;
  logic        lk_multi = 1'b0;
  logic        lk_writable = 1'b0;
  logic        lk_user = 1'b0;
  logic        lk_dirty = 1'b0;
  logic        hi_wr = 1'b0;
  logic [31:0] hi_wdata = '0;
  logic        pass_thru, need_lookup, asid_check;
  logic [7:0]  exc_vec;
  logic [31:0] fault_addr_q, pte_hi_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  va_access_gate u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .acc_va(acc_va), .ctl_xlate_en(ctl_xlate_en),
    .ctl_sv_shared(ctl_sv_shared), .ctl_sq_lock(ctl_sq_lock), .lk_hit(lk_hit),
    .lk_multi(lk_multi), .lk_writable(lk_writable), .lk_user(lk_user),
    .lk_dirty(lk_dirty), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
    .pass_thru(pass_thru), .need_lookup(need_lookup), .asid_check(asid_check),
    .exc_vec(exc_vec), .fault_addr_q(fault_addr_q), .pte_hi_q(pte_hi_q)
  );

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10, RS = 2'b11;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: drive at negedge, check decision before the edge, release after it
  task automatic try(input string tag, input logic [1:0] kind, input logic priv,
                     input logic [31:0] va, input logic at, input logic sq,
                     input logic hit, input logic multi, input logic w,
                     input logic u, input logic d, input logic e_pass,
                     input logic e_look, input logic [7:0] e_exc);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_priv = priv; acc_va = va;
    ctl_xlate_en = at; ctl_sq_lock = sq; lk_hit = hit; lk_multi = multi;
    lk_writable = w; lk_user = u; lk_dirty = d;
    #1;
    chk({tag, " pass_thru"}, 32'(pass_thru), 32'(e_pass));
    chk({tag, " need_lookup"}, 32'(need_lookup), 32'(e_look));
    chk({tag, " exc_vec"}, 32'(exc_vec), 32'(e_exc));
    chk({tag, " R9 at most one code"}, 32'($countones(exc_vec) <= 1), 32'd1);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R12 reset fault_addr", fault_addr_q, 32'h0);
    chk("R12 reset pte_hi", pte_hi_q, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12 idle outputs", {28'h0, pass_thru, need_lookup, asid_check, |exc_vec}, 32'h0);
  endtask

  task automatic t_priv_data;   // R1
    try("R1 rd 80000000",   RD, 1, 32'h8000_0000, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R1 wr BFFFFFFC",   WR, 1, 32'hBFFF_FFFC, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R1 rd FF000000",   RD, 1, 32'hFF00_0000, 1, 1, 0,0,0,0,0, 1,0,8'h00);
    try("R1 rsvd E0000000", RS, 1, 32'hE000_0000, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R1 rd C0000000",   RD, 1, 32'hC000_0000, 1, 0, 1,0,0,0,0, 0,1,8'h00);
    try("R1 wr DFFFFFFF",   WR, 1, 32'hDFFF_FFFF, 1, 0, 1,0,1,0,1, 0,1,8'h00);
  endtask

  task automatic t_user_data;   // R2
    try("R2 rd E0000010 open",  RD, 0, 32'hE000_0010, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R2 wr E3FFFFFF open",  WR, 0, 32'hE3FF_FFFF, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R2 rd E0000010 lock",  RD, 0, 32'hE000_0010, 1, 1, 0,0,0,0,0, 0,0,8'h01);
    try("R2 wr E4000000",       WR, 0, 32'hE400_0000, 1, 0, 0,0,0,0,0, 0,0,8'h02);
    try("R2 rd 80000000",       RD, 0, 32'h8000_0000, 0, 0, 0,0,0,0,0, 0,0,8'h01);
    try("R2 wr C0000000",       WR, 0, 32'hC000_0000, 1, 0, 1,0,1,1,1, 0,0,8'h02);
  endtask

  task automatic t_fetch;       // R3
    try("R3 priv A0000000",  FE, 1, 32'hA000_0000, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R3 priv E0000000",  FE, 1, 32'hE000_0000, 1, 0, 0,0,0,0,0, 0,0,8'h01);
    try("R3 user 90000000",  FE, 0, 32'h9000_0000, 0, 0, 0,0,0,0,0, 0,0,8'h01);
    try("R3 user E0000000",  FE, 0, 32'hE000_0000, 1, 0, 0,0,0,0,0, 0,0,8'h01);
    try("R3 priv C0000000",  FE, 1, 32'hC000_0000, 1, 0, 1,0,0,0,0, 0,1,8'h00);
  endtask

  task automatic t_xlate_off;   // R4
    try("R4 user rd 00400000", RD, 0, 32'h0040_0000, 0, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R4 priv rd C0001000", RD, 1, 32'hC000_1000, 0, 0, 0,0,0,0,0, 1,0,8'h00);
    try("R4 user fe 7FFFFFFF", FE, 0, 32'h7FFF_FFFF, 0, 0, 0,1,0,0,0, 1,0,8'h00);
  endtask

  task automatic t_asid;        // R5
    @(negedge clk);
    acc_valid = 1; acc_kind = RD; acc_va = 32'h0000_1000; ctl_xlate_en = 1;
    lk_hit = 1; lk_multi = 0; lk_user = 1;
    ctl_sv_shared = 1; acc_priv = 1; #1;
    chk("R5 sv=1 priv", 32'(asid_check), 32'd0);
    ctl_sv_shared = 1; acc_priv = 0; #1;
    chk("R5 sv=1 user", 32'(asid_check), 32'd1);
    ctl_sv_shared = 0; acc_priv = 1; #1;
    chk("R5 sv=0 priv", 32'(asid_check), 32'd1);
    acc_va = 32'h8000_0000; #1;
    chk("R5 no lookup", 32'(asid_check), 32'd0);
    @(negedge clk); acc_valid = 0; ctl_sv_shared = 0;
  endtask

  task automatic t_lookup;      // R6
    try("R6 multi over all", WR, 0, 32'h0000_2000, 1, 0, 0,1,0,0,0, 0,1,8'h80);
    try("R6 multi on hit",   RD, 1, 32'hC000_2000, 1, 0, 1,1,1,1,1, 0,1,8'h80);
    try("R6 rd miss",        RD, 1, 32'h0000_3000, 1, 0, 0,0,1,1,1, 0,1,8'h04);
    try("R6 wr miss",        WR, 0, 32'h0000_3000, 1, 0, 0,0,1,1,1, 0,1,8'h08);
    try("R6 fe miss",        FE, 0, 32'h0000_3000, 1, 0, 0,0,1,1,1, 0,1,8'h04);
  endtask

  task automatic t_prot;        // R7
    try("R7 priv wr not writable", WR, 1, 32'h0000_4000, 1, 0, 1,0,0,1,1, 0,1,8'h20);
    try("R7 user wr not user",     WR, 0, 32'h0000_4000, 1, 0, 1,0,1,0,1, 0,1,8'h20);
    try("R7 user rd not user",     RD, 0, 32'h0000_4000, 1, 0, 1,0,1,0,1, 0,1,8'h10);
    try("R7 user fe not user",     FE, 0, 32'h0000_4000, 1, 0, 1,0,1,0,1, 0,1,8'h10);
    try("R7 priv rd not user",     RD, 1, 32'h0000_4000, 1, 0, 1,0,0,0,0, 0,1,8'h00);
    try("R7 user wr all flags",    WR, 0, 32'h0000_4000, 1, 0, 1,0,1,1,1, 0,1,8'h00);
  endtask

  task automatic t_dirty;       // R8
    try("R8 priv wr clean page",  WR, 1, 32'h0000_5000, 1, 0, 1,0,1,0,0, 0,1,8'h40);
    try("R8 priv wr dirty page",  WR, 1, 32'h0000_5000, 1, 0, 1,0,1,0,1, 0,1,8'h00);
    try("R8 prot over dirty",     WR, 0, 32'h0000_5000, 1, 0, 1,0,1,0,0, 0,1,8'h20);
    try("R8 rd clean page",       RD, 0, 32'h0000_5000, 1, 0, 1,0,0,1,0, 0,1,8'h00);
  endtask

  task automatic t_capture;     // R10, R11
    @(negedge clk); hi_wr = 1; hi_wdata = 32'h0000_03A5;
    @(negedge clk); hi_wr = 0; #1;
    chk("R11 sw load", pte_hi_q, 32'h0000_03A5);
    try("R10 miss", RD, 1, 32'h1234_5678, 1, 0, 0,0,0,0,0, 0,1,8'h04);
    chk("R10 miss fault_addr", fault_addr_q, 32'h1234_5678);
    chk("R10 miss pte_hi", pte_hi_q, 32'h1234_57A5);
    try("R10 addr err", RD, 0, 32'h9000_0000, 1, 0, 0,0,0,0,0, 0,0,8'h01);
    chk("R10 addr err keeps fault_addr", fault_addr_q, 32'h1234_5678);
    chk("R10 addr err keeps pte_hi", pte_hi_q, 32'h1234_57A5);
    try("R10 pass", RD, 1, 32'h8000_0400, 1, 0, 0,0,0,0,0, 1,0,8'h00);
    chk("R10 pass keeps fault_addr", fault_addr_q, 32'h1234_5678);
    try("R10 init write", WR, 1, 32'h0ABC_DFFF, 1, 0, 1,0,1,0,0, 0,1,8'h40);
    chk("R10 init fault_addr", fault_addr_q, 32'h0ABC_DFFF);
    chk("R10 init pte_hi", pte_hi_q, 32'h0ABC_DFA5);
    // capture and software load together: capture wins
    @(negedge clk);
    hi_wr = 1; hi_wdata = 32'hFFFF_FFFF;
    acc_valid = 1; acc_kind = RD; acc_priv = 0; acc_va = 32'h0000_2000;
    ctl_xlate_en = 1; lk_hit = 1; lk_multi = 0; lk_user = 0;
    @(negedge clk); hi_wr = 0; acc_valid = 0; #1;
    chk("R11 capture wins pte_hi", pte_hi_q, 32'h0000_23A5);
    chk("R10 prot fault_addr", fault_addr_q, 32'h0000_2000);
    @(negedge clk); hi_wr = 1; hi_wdata = 32'hCAFE_0011;
    @(negedge clk); hi_wr = 0; #1;
    chk("R11 sw load idle", pte_hi_q, 32'hCAFE_0011);
    chk("R12 idle exc", 32'(exc_vec), 32'h0);
  endtask

  initial begin
    t_reset();
    t_priv_data();
    t_user_data();
    t_fetch();
    t_xlate_off();
    t_asid();
    t_lookup();
    t_prot();
    t_dirty();
    t_capture();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule